// File: doc/BRIEF.md
# Network Controller Interrupt Status Summarizer

This block keeps the event status word and the interrupt enable word of a network controller and drives one level-sensitive interrupt line. The receive and transmit engines report events as single-cycle pulses, one input bit per event. Each pulse latches a sticky status bit. Software reads either word through a small register port and acknowledges events by writing ones to the status word.

Two summary bits sit in the status word. The normal summary is set when any enabled completion-type event is pending. The abnormal summary is set when any enabled error or exception event is pending. Both are recomputed from the enabled events every time the events or the enables change, so a summary drops as soon as its last cause is cleared or masked. The interrupt line is high when a summary bit is set and that summary's own enable bit is also set. The line is registered, so it follows the register state one clock later.

A synchronous software-reset input returns both words to their reset values. The asynchronous reset input is released to the logic through a two-stage synchronizer.

Top module: `nic_irq_summarizer`

## Requirements
- R1: After reset the status word reads 0xF0000000, the enable word reads 0xF3FE0000 and `irq` is low.
- R2: A pulse on `ev_set[i]` sets status bit i at the next clock edge. Bits 0..4 are the normal events: transmit done, transmit buffer unavailable, receive done, timer expired and early receive. Bits 5..16 are the abnormal events: link changed, general purpose, fatal bus error, link fail, early transmit, receive watchdog, receive stopped, receive buffer unavailable, underflow, link pass, transmit jabber and transmit stopped.
- R3: A write with `wr_addr`=0 clears every status bit in 0..18 whose data bit is one and leaves every other bit unchanged. Bits 19..31 are read-only and keep their reset value.
- R4: When an event pulse and a clearing write hit the same bit in one cycle, the bit ends up set.
- R5: Status bit 17 (normal summary) is one exactly when some status bit in 0..4 and its enable bit are both one. It updates on the same edge as the event or enable change that causes it.
- R6: Status bit 18 (abnormal summary) is one exactly when some status bit in 5..16 and its enable bit are both one. It updates on the same edge.
- R7: A summary bit clears once all of its enabled causes are cleared or masked. Writing one to a summary bit while an enabled cause is still pending leaves the summary set.
- R8: `irq` equals the OR of (status bit 17 AND enable bit 17) and (status bit 18 AND enable bit 18), taken from the register values of the previous cycle.
- R9: A write with `wr_addr`=1 loads all 32 bits of the enable word. `rd_addr` selects the status word (0) or the enable word (1) on `rd_data`.
- R10: `sw_rst` loads both words with their reset values. It wins over a same-cycle event or write, and `irq` is low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset pulse |
| ev_set | input | 17 | Event pulses, one bit per status event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 status, 1 enable |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read select: 0 status, 1 enable |
| rd_data | output | 32 | Selected register value |
| irq | output | 1 | Level interrupt request |

## Verification
The main sweep goes through every one of the 17 events. For each event it tries all eight combinations of the event's own enable bit and the two summary enable bits. This separates a summary that ignores masking, an event assigned to the wrong group, and an interrupt that ignores the summary enables. Each case is followed by a write-one clear, which shows that the summary falls with its cause. Directed patterns then cover an event colliding with a clear, a clear of a summary whose cause is still pending, a write of zeros, the read-only upper bits, the one-cycle interrupt lag, and software reset colliding with events and writes.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned N_NORM      = 5;
  localparam int unsigned N_ABN       = 12;
  localparam int unsigned N_EV        = N_NORM + N_ABN;
  localparam int unsigned NORM_SUM_B  = N_EV;
  localparam int unsigned ABN_SUM_B   = N_EV + 1;
  localparam int unsigned N_CLR       = N_EV + 2;

  localparam logic [N_EV-1:0] NORM_MASK = {{N_ABN{1'b0}}, {N_NORM{1'b1}}};
  localparam logic [N_EV-1:0] ABN_MASK  = {{N_ABN{1'b1}}, {N_NORM{1'b0}}};

  localparam logic [REG_W-1:0] STAT_RST = 32'hF000_0000;
  localparam logic [REG_W-1:0] EN_RST   = 32'hF3FE_0000;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/nic_irq_rst_sync.sv
module nic_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/nic_irq_event_bank.sv
module nic_irq_event_bank
  import nic_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_rst,
  input  logic [N_EV-1:0] ev_set,
  input  logic            clr_en,
  input  logic [N_EV-1:0] clr_bits,
  output logic [N_EV-1:0] ev_d,
  output logic [N_EV-1:0] ev_q
);
  localparam logic [N_EV-1:0] EV_RST = STAT_RST[N_EV-1:0];

  for (genvar b = 0; b < N_EV; b++) begin : g_bit
    logic load;
    logic nxt;

    always_comb begin
      load = sw_rst | ev_set[b] | (clr_en & clr_bits[b]);
      if (sw_rst)         nxt = EV_RST[b];
      else if (ev_set[b]) nxt = 1'b1;      // new event beats a clear
      else                nxt = 1'b0;      // clear request
      ev_d[b] = load ? nxt : ev_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ev_q[b] <= EV_RST[b];
      else if (load) ev_q[b] <= nxt;
    end
  end
endmodule

// File: rtl/nic_irq_enable_reg.sv
module nic_irq_enable_reg
  import nic_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] en_d,
  output logic [REG_W-1:0] en_q
);
  logic load;

  always_comb begin
    load = sw_rst | wr_stb;
    if (sw_rst)      en_d = EN_RST;
    else if (wr_stb) en_d = wr_data;
    else             en_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= EN_RST;
    else if (load) en_q <= en_d;
  end
endmodule

// File: rtl/nic_irq_summary.sv
module nic_irq_summary
  import nic_irq_pkg::*;
(
  input  logic [N_EV-1:0] ev,
  input  logic [N_EV-1:0] en,
  output logic            norm,
  output logic            abn
);
  logic [N_EV-1:0] live;

  always_comb begin
    live = ev & en;
    norm = |(live & NORM_MASK);
    abn  = |(live & ABN_MASK);
  end
endmodule

// File: rtl/nic_irq_summarizer.sv
module nic_irq_summarizer
  import nic_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic [N_EV-1:0]  ev_set,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  logic             rst_int_n;
  logic             stat_wr;
  logic             en_wr;
  logic [N_EV-1:0]  ev_d;
  logic [N_EV-1:0]  ev_q;
  logic [REG_W-1:0] en_d;
  logic [REG_W-1:0] en_q;
  logic             norm_d;
  logic             abn_d;
  logic             norm_q;
  logic             abn_q;
  logic             irq_d;
  logic             irq_q;
  logic [REG_W-1:0] stat_word;

  nic_irq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign stat_wr = wr_en & (wr_addr == SEL_STATUS);
  assign en_wr   = wr_en & (wr_addr == SEL_ENABLE);

  nic_irq_event_bank u_events (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sw_rst   (sw_rst),
    .ev_set   (ev_set),
    .clr_en   (stat_wr),
    .clr_bits (wr_data[N_EV-1:0]),
    .ev_d     (ev_d),
    .ev_q     (ev_q)
  );

  nic_irq_enable_reg u_enable (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sw_rst  (sw_rst),
    .wr_stb  (en_wr),
    .wr_data (wr_data),
    .en_d    (en_d),
    .en_q    (en_q)
  );

  // summaries are rebuilt from the next-state events and enables, so a
  // write of ones to a summary bit only sticks if no enabled cause remains
  nic_irq_summary u_summary (
    .ev   (ev_d),
    .en   (en_d[N_EV-1:0]),
    .norm (norm_d),
    .abn  (abn_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      norm_q <= STAT_RST[NORM_SUM_B];
      abn_q  <= STAT_RST[ABN_SUM_B];
    end else begin
      norm_q <= norm_d;
      abn_q  <= abn_d;
    end
  end

  // interrupt is taken from registered state only
  always_comb begin
    irq_d = (norm_q & en_q[NORM_SUM_B]) | (abn_q & en_q[ABN_SUM_B]);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end

  always_comb begin
    stat_word              = STAT_RST;
    stat_word[N_EV-1:0]    = ev_q;
    stat_word[NORM_SUM_B]  = norm_q;
    stat_word[ABN_SUM_B]   = abn_q;
  end

  assign rd_data = (rd_addr == SEL_ENABLE) ? en_q : stat_word;
  assign irq     = irq_q;
endmodule

// File: rtl/nic_irq_checker.sv
module nic_irq_checker
  import nic_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic [N_EV-1:0]  ev_set,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] stat_word,
  input  logic [REG_W-1:0] en_q,
  input  logic             irq
);
  // R10
  sw_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (stat_word == STAT_RST && en_q == EN_RST));

  // R2
  event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && (|ev_set)) |=>
      ((stat_word[N_EV-1:0] & $past(ev_set)) == $past(ev_set)));

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && wr_en && wr_addr == 1'b0) |=>
      ((stat_word[N_EV-1:0] & $past(wr_data[N_EV-1:0] & ~ev_set)) == '0));

  // R8
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(stat_word[ABN_SUM_B:NORM_SUM_B] &
                              en_q[ABN_SUM_B:NORM_SUM_B]))));

  // R5
  norm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[NORM_SUM_B] |-> |(stat_word[N_EV-1:0] & en_q[N_EV-1:0] & NORM_MASK));

  // R6
  abn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[ABN_SUM_B] |-> |(stat_word[N_EV-1:0] & en_q[N_EV-1:0] & ABN_MASK));
endmodule

bind nic_irq_summarizer nic_irq_checker u_nic_irq_checker (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .sw_rst    (sw_rst),
  .ev_set    (ev_set),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .stat_word (stat_word),
  .en_q      (en_q),
  .irq       (irq)
);

// File: tb/test_nic_irq_summarizer.sv
module test_nic_irq_summarizer;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NEV = 17;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_rst;
  logic [16:0] ev_set;
  logic        wr_en;
  logic        wr_addr;
  logic [31:0] wr_data;
  logic        rd_addr;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0;
  int bad   = 0;

  logic [16:0] m_ev;
  logic [31:0] m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_irq_summarizer i_nic_irq_summarizer (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .ev_set(ev_set),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic m_norm();
    return |(m_ev & m_en[16:0] & 17'h0001F);
  endfunction

  function automatic logic m_abn();
    return |(m_ev & m_en[16:0] & 17'h1FFE0);
  endfunction

  function automatic logic [31:0] m_status();
    return 32'hF000_0000 | ({31'd0, m_abn()} << 18) | ({31'd0, m_norm()} << 17) |
           {15'd0, m_ev};
  endfunction

  function automatic logic m_irq();
    return (m_norm() & m_en[17]) | (m_abn() & m_en[18]);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clocked operation; model updated with the same edge
  task automatic op(logic [16:0] evs, logic we, logic wa, logic [31:0] wd, logic swr);
    @(negedge clk);
    ev_set = evs; wr_en = we; wr_addr = wa; wr_data = wd; sw_rst = swr;
    @(posedge clk);
    #1;
    ev_set = '0; wr_en = 1'b0; wr_data = '0; sw_rst = 1'b0;
    if (swr) begin
      m_ev = 17'd0;
      m_en = 32'hF3FE_0000;
    end else begin
      if (we && !wa) m_ev = m_ev & ~wd[16:0];
      m_ev = m_ev | evs;
      if (we && wa) m_en = wd;
    end
  endtask

  task automatic check_regs(string req);
    @(negedge clk);
    rd_addr = 1'b0; #1;
    check(req, rd_data, m_status());
    rd_addr = 1'b1; #1;
    check(req, rd_data, m_en);
  endtask

  task automatic check_irq(string req);
    @(negedge clk);
    check(req, {31'd0, irq}, {31'd0, m_irq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sw_rst = 1'b0; ev_set = '0; wr_en = 1'b0;
    wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b0;
    m_ev = '0; m_en = 32'hF3FE_0000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    check_regs("R1");
    check_irq("R1");

    // R2 R5 R6 R7 R8 sweep: every event x own/summary enable combinations
    for (int i = 0; i < NEV; i++) begin
      for (int m = 0; m < 8; m++) begin
        logic [31:0] en_val;
        en_val = 32'd0;
        if (m[0]) en_val[i]  = 1'b1;
        if (m[1]) en_val[17] = 1'b1;
        if (m[2]) en_val[18] = 1'b1;
        op('0, 1'b1, 1'b1, en_val, 1'b0);
        op(17'd1 << i, 1'b0, 1'b0, '0, 1'b0);
        check_regs(i < 5 ? "R2/R5" : "R2/R6");
        check_irq("R8");
        op('0, 1'b1, 1'b0, 32'd1 << i, 1'b0);
        check_regs("R3/R7");
        check_irq("R8");
      end
    end

    // R4 event wins over same-cycle clear
    op(17'h1FFFF, 1'b0, 1'b0, '0, 1'b0);
    op(17'h00008, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0);
    check_regs("R4");

    // R3 zero write changes nothing, upper bits read-only
    op(17'h00401, 1'b0, 1'b0, '0, 1'b0);
    op('0, 1'b1, 1'b0, 32'h0000_0000, 1'b0);
    check_regs("R3");
    op('0, 1'b1, 1'b0, 32'hFFF8_0000, 1'b0);
    check_regs("R3");

    // R7 clearing a summary bit with its cause still enabled
    op('0, 1'b1, 1'b1, 32'h0006_0001, 1'b0);
    op('0, 1'b1, 1'b0, 32'h0002_0000, 1'b0);
    check_regs("R7");
    @(negedge clk); rd_addr = 1'b0; #1;
    check("R7", {31'd0, rd_data[17]}, 32'd1);
    // masking the cause drops the summary
    op('0, 1'b1, 1'b1, 32'h0006_0000, 1'b0);
    check_regs("R7");

    // R8 one-cycle lag: irq stays old right after the enabling write
    op('0, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0);
    op('0, 1'b1, 1'b1, 32'h0006_0020, 1'b0);
    op(17'h00020, 1'b0, 1'b0, '0, 1'b0);
    check("R8", {31'd0, irq}, 32'd0);
    @(posedge clk); #1;
    check("R8", {31'd0, irq}, 32'd1);

    // R9 enable register full write and readback
    op('0, 1'b1, 1'b1, 32'hA5A5_5A5A, 1'b0);
    check_regs("R9");
    op('0, 1'b1, 1'b1, 32'h5A5A_A5A5, 1'b0);
    check_regs("R9");

    // R10 software reset beats same-cycle event and write
    op('0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0);
    op(17'h1FFFF, 1'b0, 1'b0, '0, 1'b0);
    check_irq("R10");
    op(17'h1FFFF, 1'b1, 1'b1, 32'h0000_0001, 1'b1);
    check_regs("R10");
    check_irq("R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule